// File: doc/BRIEF.md
# Adaptive FIR Filter with Error-Driven Step Size

This block is a single-channel adaptive transversal filter. Each accepted sample pair holds one reference sample and one desired sample. The pair shifts the reference into a tap delay line and forms the filter output as the inner product of the tap weights and the delay line. The error is the desired sample minus that output. All tap weights are then adjusted with the LMS rule: each weight gains the step size times the error times the input sample at that tap.

The step size is not a constant. After every accepted sample it is recomputed from its own previous value, scaled by a leak factor, plus a gain times the rounded squared error. The result is clamped to a window. A large error early in adaptation pushes the step size up towards the upper bound, which sits near the plain-LMS stability limit. As the error shrinks, the step size decays towards the lower bound, and this lowers steady-state misadjustment. All arithmetic is signed fixed point with a binary point FRAC bits from the right. Every result saturates to its storage width instead of wrapping.

The block is used in streaming noise-cancellation or system-identification paths. Leak, gain and the bounds are elaboration parameters.

Top module: `lms_vss`

## Requirements
- R1: While reset is asserted and right after it is released, y_out, e_out and all tap weights and delay-line entries are zero, out_valid is low and mu_out equals MU_MAX.
- R2: A sample is taken only in a cycle where x_valid and d_valid are both high. A cycle with only one strobe high has no effect: out_valid stays low and y_out, e_out, mu_out, the weights and the delay line keep their values.
- R3: out_valid is high for exactly the one cycle after a taken sample. y_out, e_out and mu_out change only on that edge.
- R4: y_out = saturate_DW((sum over taps i of w_i * x_i) >>> FRAC). Tap 0 holds the sample just taken and tap i holds the one taken i samples earlier. The weights are those from before this sample.
- R5: e_out = saturate_DW(d_in - y), where the difference saturates at the most negative or most positive DW-bit value instead of wrapping.
- R6: Each weight becomes saturate_WW(w_i + ((((mu * e) >>> FRAC) * x_i) >>> FRAC)). Here mu is the step size held before this sample and x_i is the updated delay line.
- R7: The next step size is ((LEAK * mu) >>> FRAC) + ((GAIN * ((e*e + 2^(FRAC-1)) >>> FRAC)) >>> FRAC). All shifts are arithmetic and floor the result.
- R8: mu_out always stays within [MU_MIN, MU_MAX] and is clamped to the nearer bound when the recursion leaves the window. A sustained large error drives it to MU_MAX.
- R9: A taken sample whose error is zero never raises the step size. A long run of zero error brings it to MU_MIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in | input | DW | Reference sample, signed fixed point |
| x_valid | input | 1 | Reference sample strobe |
| d_in | input | DW | Desired sample, signed fixed point |
| d_valid | input | 1 | Desired sample strobe |
| y_out | output | DW | Filter output for the last taken sample |
| e_out | output | DW | Error for the last taken sample |
| mu_out | output | MUW | Step size after the last update, unsigned Q0.FRAC |
| out_valid | output | 1 | One-cycle pulse marking fresh outputs |

## Verification
The bound checker checks the following on every cycle:
- the step size stays inside its window;
- out_valid pulses after each taken pair and only then;
- the outputs hold steady whenever a cycle takes no sample;
- a zero-error sample never raises the step size.

The arithmetic itself can only be shown by the bench's scenarios, which compare every output against a model built from the equations above. The inner product and delay-line order, the weight update with the older step size, and the rounding of the squared error are all checked this way. So are the climb to MU_MAX under a large error, the decay to MU_MIN under zero error, the saturated error after training, and the proof, seen on the next full sample, that a lone strobe left the delay line untouched.

// File: rtl/lms_vss_pkg.sv
package lms_vss_pkg;

    // sign-extend the low w bits of v to 64 bits
    function automatic logic signed [63:0] sx64(input logic [63:0] v, input int w);
        logic signed [63:0] t;
        t = signed'(v << (64 - w));
        return t >>> (64 - w);
    endfunction

    // saturate a 64-bit signed value to a w-bit signed range
    function automatic logic signed [63:0] clip_s(input logic signed [63:0] v, input int w);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -hi - 64'sd1;
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/lms_vss_dot.sv
module lms_vss_dot
    import lms_vss_pkg::*;
#(
    parameter int TAPS = 4,
    parameter int DW   = 16,
    parameter int WW   = 16,
    parameter int FRAC = 15
) (
    input  logic [TAPS-1:0][DW-1:0] xv,
    input  logic [TAPS-1:0][WW-1:0] wv,
    output logic [DW-1:0]           y
);
    logic signed [63:0] prod [TAPS];
    logic signed [63:0] acc;

    for (genvar i = 0; i < TAPS; i++) begin : g_mul
        assign prod[i] = sx64(64'(xv[i]), DW) * sx64(64'(wv[i]), WW);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < TAPS; i++) begin
            acc = acc + prod[i];
        end
        y = DW'(clip_s(acc >>> FRAC, DW));
    end
endmodule

// File: rtl/lms_vss_adapt.sv
module lms_vss_adapt
    import lms_vss_pkg::*;
#(
    parameter int TAPS = 4,
    parameter int DW   = 16,
    parameter int WW   = 16,
    parameter int MUW  = 16,
    parameter int FRAC = 15
) (
    input  logic [MUW-1:0]          mu,
    input  logic [DW-1:0]           err,
    input  logic [TAPS-1:0][DW-1:0] xv,
    input  logic [TAPS-1:0][WW-1:0] wv,
    output logic [TAPS-1:0][WW-1:0] w_nx
);
    logic signed [63:0] scaled_err;
    logic signed [63:0] delta [TAPS];

    always_comb begin
        scaled_err = (signed'(64'(mu)) * sx64(64'(err), DW)) >>> FRAC;
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign delta[i] = (scaled_err * sx64(64'(xv[i]), DW)) >>> FRAC;
        assign w_nx[i]  = WW'(clip_s(sx64(64'(wv[i]), WW) + delta[i], WW));
    end
endmodule

// File: rtl/lms_vss_step.sv
module lms_vss_step
    import lms_vss_pkg::*;
#(
    parameter int DW     = 16,
    parameter int MUW    = 16,
    parameter int FRAC   = 15,
    parameter int LEAK   = 31130,
    parameter int GAIN   = 3277,
    parameter int MU_MIN = 328,
    parameter int MU_MAX = 16384
) (
    input  logic [MUW-1:0] mu,
    input  logic [DW-1:0]  err,
    output logic [MUW-1:0] mu_nx
);
    localparam logic signed [63:0] LEAK_V = 64'(LEAK);
    localparam logic signed [63:0] GAIN_V = 64'(GAIN);
    localparam logic signed [63:0] LO_V   = 64'(MU_MIN);
    localparam logic signed [63:0] HI_V   = 64'(MU_MAX);
    localparam logic signed [63:0] HALF_V = 64'sd1 <<< (FRAC - 1);

    logic signed [63:0] e_v;
    logic signed [63:0] esq_r;
    logic signed [63:0] sum_v;

    always_comb begin
        e_v   = sx64(64'(err), DW);
        esq_r = (e_v * e_v + HALF_V) >>> FRAC;
        sum_v = ((LEAK_V * signed'(64'(mu))) >>> FRAC) + ((GAIN_V * esq_r) >>> FRAC);
        if (sum_v > HI_V)      mu_nx = MUW'(HI_V);
        else if (sum_v < LO_V) mu_nx = MUW'(LO_V);
        else                   mu_nx = MUW'(sum_v);
    end
endmodule

// File: rtl/lms_vss.sv
module lms_vss
    import lms_vss_pkg::*;
#(
    parameter int TAPS   = 4,
    parameter int DW     = 16,
    parameter int WW     = 16,
    parameter int MUW    = 16,
    parameter int FRAC   = 15,
    parameter int LEAK   = 31130,
    parameter int GAIN   = 3277,
    parameter int MU_MIN = 328,
    parameter int MU_MAX = 16384
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  x_in,
    input  logic           x_valid,
    input  logic [DW-1:0]  d_in,
    input  logic           d_valid,
    output logic [DW-1:0]  y_out,
    output logic [DW-1:0]  e_out,
    output logic [MUW-1:0] mu_out,
    output logic           out_valid
);
    localparam logic [MUW-1:0] MU_RST = MUW'(MU_MAX);

    typedef struct packed {
        logic [TAPS-1:0][DW-1:0] taps;
        logic [TAPS-1:0][WW-1:0] w;
        logic [DW-1:0]           y;
        logic [DW-1:0]           e;
        logic [MUW-1:0]          mu;
        logic                    ov;
    } state_t;

    state_t st_d, st_q;

    logic                    take;
    logic [TAPS-1:0][DW-1:0] line_nx;
    logic [DW-1:0]           y_c;
    logic [DW-1:0]           e_c;
    logic [TAPS-1:0][WW-1:0] w_nx;
    logic [MUW-1:0]          mu_nx;

    assign take = x_valid && d_valid;

    // delay line with the new sample at tap 0
    always_comb begin
        line_nx[0] = x_in;
        for (int i = 1; i < TAPS; i++) begin
            line_nx[i] = st_q.taps[i-1];
        end
    end

    lms_vss_dot #(.TAPS(TAPS), .DW(DW), .WW(WW), .FRAC(FRAC)) u_dot (
        .xv (line_nx),
        .wv (st_q.w),
        .y  (y_c)
    );

    always_comb begin
        e_c = DW'(clip_s(sx64(64'(d_in), DW) - sx64(64'(y_c), DW), DW));
    end

    lms_vss_adapt #(.TAPS(TAPS), .DW(DW), .WW(WW), .MUW(MUW), .FRAC(FRAC)) u_adapt (
        .mu   (st_q.mu),
        .err  (e_c),
        .xv   (line_nx),
        .wv   (st_q.w),
        .w_nx (w_nx)
    );

    lms_vss_step #(
        .DW(DW), .MUW(MUW), .FRAC(FRAC), .LEAK(LEAK), .GAIN(GAIN),
        .MU_MIN(MU_MIN), .MU_MAX(MU_MAX)
    ) u_step (
        .mu    (st_q.mu),
        .err   (e_c),
        .mu_nx (mu_nx)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        if (take) begin
            st_d.taps = line_nx;
            st_d.w    = w_nx;
            st_d.y    = y_c;
            st_d.e    = e_c;
            st_d.mu   = mu_nx;
            st_d.ov   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{taps: '0, w: '0, y: '0, e: '0, mu: MU_RST, ov: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign y_out     = st_q.y;
    assign e_out     = st_q.e;
    assign mu_out    = st_q.mu;
    assign out_valid = st_q.ov;
endmodule

// File: rtl/lms_vss_chk.sv
module lms_vss_chk #(
    parameter int DW     = 16,
    parameter int MUW    = 16,
    parameter int MU_MIN = 328,
    parameter int MU_MAX = 16384
) (
    input logic           clk,
    input logic           rst_n,
    input logic           x_valid,
    input logic           d_valid,
    input logic [DW-1:0]  y_out,
    input logic [DW-1:0]  e_out,
    input logic [MUW-1:0] mu_out,
    input logic           out_valid
);
    localparam logic [MUW-1:0] LO_V = MUW'(MU_MIN);
    localparam logic [MUW-1:0] HI_V = MUW'(MU_MAX);

    assert_mu_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mu_out >= LO_V) && (mu_out <= HI_V));

    assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && d_valid) |=> out_valid);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_valid && d_valid) |=> (!out_valid && $stable(y_out) && $stable(e_out) && $stable(mu_out)));

    assert_zero_err_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && e_out == '0) |-> (mu_out <= $past(mu_out)));
endmodule

bind lms_vss lms_vss_chk #(.DW(DW), .MUW(MUW), .MU_MIN(MU_MIN), .MU_MAX(MU_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_valid   (x_valid),
    .d_valid   (d_valid),
    .y_out     (y_out),
    .e_out     (e_out),
    .mu_out    (mu_out),
    .out_valid (out_valid)
);

// File: tb/lms_vss_test.sv
module lms_vss_test;
    localparam int TAPS = 4, DW = 16, WW = 16, MUW = 16, FRAC = 15;
    localparam int LEAK = 31130, GAIN = 3277, MU_MIN = 328, MU_MAX = 16384;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n;
    logic [DW-1:0]  x_in, d_in;
    logic           x_valid, d_valid;
    logic [DW-1:0]  y_out, e_out;
    logic [MUW-1:0] mu_out;
    logic           out_valid;

    lms_vss #(
        .TAPS(TAPS), .DW(DW), .WW(WW), .MUW(MUW), .FRAC(FRAC),
        .LEAK(LEAK), .GAIN(GAIN), .MU_MIN(MU_MIN), .MU_MAX(MU_MAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .x_valid(x_valid),
        .d_in(d_in), .d_valid(d_valid), .y_out(y_out), .e_out(e_out),
        .mu_out(mu_out), .out_valid(out_valid)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    longint mx [TAPS];
    longint mw [TAPS];
    longint m_y, m_e, m_mu;

    function automatic longint clipv(longint v, int w);
        longint hi, lo;
        hi = (64'sd1 <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < TAPS; i++) begin
            mx[i] = 0;
            mw[i] = 0;
        end
        m_y = 0; m_e = 0; m_mu = MU_MAX;
    endtask

    task automatic model_step(longint x, longint d);
        longint nx [TAPS];
        longint acc, y, e, se, esq, s;
        nx[0] = x;
        for (int i = 1; i < TAPS; i++) nx[i] = mx[i-1];
        acc = 0;
        for (int i = 0; i < TAPS; i++) acc += mw[i] * nx[i];
        y  = clipv(acc >>> FRAC, DW);
        e  = clipv(d - y, DW);
        se = (m_mu * e) >>> FRAC;
        for (int i = 0; i < TAPS; i++) mw[i] = clipv(mw[i] + ((se * nx[i]) >>> FRAC), WW);
        esq = (e * e + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
        s = ((LEAK * m_mu) >>> FRAC) + ((GAIN * esq) >>> FRAC);
        if (s > MU_MAX) s = MU_MAX;
        if (s < MU_MIN) s = MU_MIN;
        for (int i = 0; i < TAPS; i++) mx[i] = nx[i];
        m_y = y; m_e = e; m_mu = s;
    endtask

    // one cycle of stimulus, then compare every output to the model
    task automatic put(longint x, longint d, bit xv, bit dv, string req);
        @(negedge clk);
        x_in = DW'(x); d_in = DW'(d); x_valid = xv; d_valid = dv;
        if (xv && dv) model_step(x, d);
        @(negedge clk);
        x_valid = 1'b0; d_valid = 1'b0;
        chk({req, " out_valid"}, longint'(out_valid), longint'(xv && dv));
        chk({req, " y"}, longint'($signed(y_out)), m_y);
        chk({req, " e"}, longint'($signed(e_out)), m_e);
        chk({req, " mu"}, longint'(mu_out), m_mu);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; x_valid = 1'b0; d_valid = 1'b0; x_in = '0; d_in = '0;
        repeat (3) @(negedge clk);
        model_reset();
        chk("R1 mu in reset", longint'(mu_out), MU_MAX);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 y after reset", longint'($signed(y_out)), 0);
        chk("R1 e after reset", longint'($signed(e_out)), 0);
        chk("R1 mu after reset", longint'(mu_out), MU_MAX);
        chk("R1 out_valid after reset", longint'(out_valid), 0);
        // zero weights: first sample gives y = 0, e = d
        put(1000, 5000, 1'b1, 1'b1, "R1 first sample");
        chk("R1 first e equals d", longint'($signed(e_out)), 5000);
    endtask

    task automatic t_track();
        for (int k = 0; k < 60; k++) begin
            longint x, d;
            x = longint'((k * 5273) % 24001) - 12000;
            d = (k % 3 == 0) ? -x : (x / 2 + 700 * (k % 5));
            put(x, d, 1'b1, 1'b1, "R4 R5 R6 R7 R3 track");
        end
    endtask

    task automatic t_ignore();
        put(9999, 0, 1'b1, 1'b0, "R2 reference strobe only");
        put(0, -7777, 1'b0, 1'b1, "R2 desired strobe only");
        put(0, 0, 1'b0, 1'b0, "R2 no strobe");
        // delay line and weights must be untouched: next full sample matches model
        put(3000, -2000, 1'b1, 1'b1, "R2 delay line untouched");
    endtask

    task automatic t_decay();
        for (int k = 0; k < 150; k++) put(0, 0, 1'b1, 1'b1, "R9 zero error");
        chk("R9 R8 decay reaches MU_MIN", longint'(mu_out), MU_MIN);
    endtask

    task automatic t_rise();
        for (int k = 0; k < 12; k++) put(0, 30000, 1'b1, 1'b1, "R7 large error");
        chk("R8 climb reaches MU_MAX", longint'(mu_out), MU_MAX);
    endtask

    task automatic t_sat();
        for (int k = 0; k < 40; k++) put(16384, 32767, 1'b1, 1'b1, "R6 train");
        put(16384, -32768, 1'b1, 1'b1, "R5 saturating error");
        chk("R5 error clipped to negative limit", longint'($signed(e_out)), -32768);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_track();
        t_ignore();
        t_decay();
        t_rise();
        t_reset();
        t_sat();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule